// File: doc/BRIEF.md
# Accumulator Rotate and Decimal Adjust Unit

A purely combinational helper for an 8-bit processor datapath that covers the operations acting on the accumulator alone. These are four rotate flavours, a decimal adjust after binary addition of packed BCD digits, a bitwise invert of the accumulator, a forced carry set and a carry toggle. The unit takes the current accumulator, the carry and half-carry flags and a 3-bit operation code. It returns the next accumulator and flag values in the same cycle.

A five-bit write-enable mask tells the surrounding flag register which flags to load. Flags whose mask bit is clear must be kept by the caller. The zero, sign and parity outputs carry meaning only for decimal adjust and are driven low for every other code. The main ALU, the register file and instruction sequencing live elsewhere.

Top module: `acc_rotdaa`

## Requirements
- R1: Operation code 0 (rotate left circular) gives acc_out = {acc_in[6:0], acc_in[7]} and cy_out = acc_in[7].
- R2: Operation code 1 (rotate right circular) gives acc_out = {acc_in[0], acc_in[7:1]} and cy_out = acc_in[0].
- R3: Operation code 2 (rotate left through carry) gives acc_out = {acc_in[6:0], cy_in} and cy_out = acc_in[7].
- R4: Operation code 3 (rotate right through carry) gives acc_out = {cy_in, acc_in[7:1]} and cy_out = acc_in[0].
- R5: For codes 0 to 3, upd_mask is 5'b00001, so only carry is updated, and hc_out equals hc_in.
- R6: Code 4 (decimal adjust), first step: when acc_in[3:0] > 9 or hc_in is 1, 0x06 is added, and hc_out is 1 exactly when acc_in[3:0] > 9. Otherwise nothing is added and hc_out is 0.
- R7: Code 4, second step: let V be the value after the first step. When V[7:4] > 9 or cy_in is 1, 0x60 is added modulo 256, and cy_out is 1 exactly when V[7:4] > 9. Otherwise cy_out is 0.
- R8: For code 4, zero_out = (acc_out == 0), sign_out = acc_out[7], and par_out = 1 when acc_out has an even number of ones. upd_mask is 5'b11111.
- R9: Code 5 (invert accumulator) gives acc_out = ~acc_in and upd_mask = 0, with cy_out = cy_in and hc_out = hc_in.
- R10: Code 6 forces cy_out = 1, and code 7 gives cy_out = ~cy_in. Both leave acc_out = acc_in and hc_out = hc_in, with upd_mask = 5'b00001.
- R11: For every code except 4, zero_out, sign_out and par_out are 0.
- R12: upd_mask bit positions are: bit 0 carry, bit 1 half-carry, bit 2 zero, bit 3 sign, bit 4 parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code 0..7 |
| acc_in | input | 8 | Current accumulator |
| cy_in | input | 1 | Current carry flag |
| hc_in | input | 1 | Current half-carry flag |
| acc_out | output | 8 | Next accumulator |
| cy_out | output | 1 | Next carry flag |
| hc_out | output | 1 | Next half-carry flag |
| zero_out | output | 1 | Zero flag (decimal adjust only) |
| sign_out | output | 1 | Sign flag (decimal adjust only) |
| par_out | output | 1 | Even-parity flag (decimal adjust only) |
| upd_mask | output | 5 | Per-flag write enable |

## Verification
Every result is due in the same cycle as its inputs, because no register lies between any input and any output. The bench applies one vector shortly after a rising edge and compares all outputs at the following falling edge, after the logic has settled and before the next vector arrives. The sweep covers all eight codes, all 256 accumulator values and all four carry/half-carry pairs. This includes the nibble thresholds at 9 and 10 and the decimal adjust cases that clear a carry which was set on input.

// File: rtl/acc_rotdaa.sv
module acc_rotdaa (
  input  logic [2:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic       cy_in,
  input  logic       hc_in,
  output logic [7:0] acc_out,
  output logic       cy_out,
  output logic       hc_out,
  output logic       zero_out,
  output logic       sign_out,
  output logic       par_out,
  output logic [4:0] upd_mask
);
  localparam logic [2:0] OP_ROL  = 3'd0;
  localparam logic [2:0] OP_ROR  = 3'd1;
  localparam logic [2:0] OP_RLC  = 3'd2;
  localparam logic [2:0] OP_RRC  = 3'd3;
  localparam logic [2:0] OP_BCD  = 3'd4;
  localparam logic [2:0] OP_INV  = 3'd5;
  localparam logic [2:0] OP_SETC = 3'd6;
  localparam logic [2:0] OP_TGLC = 3'd7;

  localparam logic [4:0] M_CY  = 5'b00001;
  localparam logic [4:0] M_ALL = 5'b11111;

  logic       lo_big, lo_fix, hi_big, hi_fix;
  logic [7:0] step1, step2;

  assign lo_big = acc_in[3:0] > 4'd9;
  assign lo_fix = lo_big | hc_in;
  assign step1  = lo_fix ? acc_in + 8'h06 : acc_in;
  assign hi_big = step1[7:4] > 4'd9;
  assign hi_fix = hi_big | cy_in;
  assign step2  = hi_fix ? step1 + 8'h60 : step1;

  always_comb begin
    acc_out  = acc_in;
    cy_out   = cy_in;
    hc_out   = hc_in;
    zero_out = 1'b0;
    sign_out = 1'b0;
    par_out  = 1'b0;
    upd_mask = M_CY;
    case (op_sel)
      OP_ROL: begin
        acc_out = {acc_in[6:0], acc_in[7]};
        cy_out  = acc_in[7];
      end
      OP_ROR: begin
        acc_out = {acc_in[0], acc_in[7:1]};
        cy_out  = acc_in[0];
      end
      OP_RLC: begin
        acc_out = {acc_in[6:0], cy_in};
        cy_out  = acc_in[7];
      end
      OP_RRC: begin
        acc_out = {cy_in, acc_in[7:1]};
        cy_out  = acc_in[0];
      end
      OP_BCD: begin
        acc_out  = step2;
        hc_out   = lo_fix & lo_big;
        cy_out   = hi_fix & hi_big;
        zero_out = step2 == 8'h00;
        sign_out = step2[7];
        par_out  = ~^step2;
        upd_mask = M_ALL;
      end
      OP_INV: begin
        acc_out  = ~acc_in;
        upd_mask = 5'b00000;
      end
      OP_SETC: cy_out = 1'b1;
      OP_TGLC: cy_out = ~cy_in;
      default: ;
    endcase
  end
endmodule

module acc_rotdaa_chk (
  input logic [2:0] op_sel,
  input logic [7:0] acc_in,
  input logic       cy_in,
  input logic       hc_in,
  input logic [7:0] acc_out,
  input logic       cy_out,
  input logic       hc_out,
  input logic       zero_out,
  input logic       sign_out,
  input logic       par_out,
  input logic [4:0] upd_mask
);
  always_comb begin
    if (op_sel == 3'd0 || op_sel == 3'd2) begin
      // R1
      rol_cy_chk: assert (cy_out == acc_in[7] && acc_out[7:1] == acc_in[6:0]);
    end
    if (op_sel == 3'd1 || op_sel == 3'd3) begin
      // R2
      ror_cy_chk: assert (cy_out == acc_in[0] && acc_out[6:0] == acc_in[7:1]);
    end
    if (op_sel[2] == 1'b0) begin
      // R5
      rot_mask_chk: assert (upd_mask == 5'b00001 && hc_out == hc_in);
    end
    if (op_sel == 3'd4) begin
      // R8
      bcd_zero_chk: assert (zero_out == (acc_out == 8'h00) && sign_out == acc_out[7]);
      // R6
      bcd_lo_chk: assert (!(acc_in[3:0] <= 4'd9 && !hc_in) || (acc_out[3:0] == acc_in[3:0] && !hc_out));
    end else begin
      // R11
      no_zsp_chk: assert (!zero_out && !sign_out && !par_out);
    end
    if (op_sel == 3'd5) begin
      // R9
      inv_chk: assert ((acc_out ^ acc_in) == 8'hFF && upd_mask == 5'b00000 && cy_out == cy_in);
    end
    if (op_sel == 3'd6) begin
      // R10
      setc_chk: assert (cy_out && acc_out == acc_in && hc_out == hc_in);
    end
  end
endmodule

bind acc_rotdaa acc_rotdaa_chk u_chk (.*);

// File: tb/acc_rotdaa_tb.sv
module acc_rotdaa_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0] op_sel;
  logic [7:0] acc_in;
  logic       cy_in, hc_in;
  logic [7:0] acc_out;
  logic       cy_out, hc_out, zero_out, sign_out, par_out;
  logic [4:0] upd_mask;

  acc_rotdaa u_dut (
    .op_sel(op_sel), .acc_in(acc_in), .cy_in(cy_in), .hc_in(hc_in),
    .acc_out(acc_out), .cy_out(cy_out), .hc_out(hc_out),
    .zero_out(zero_out), .sign_out(sign_out), .par_out(par_out),
    .upd_mask(upd_mask)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int e_acc, e_cy, e_hc, e_z, e_s, e_p, e_m;

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6/R7";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input int op, input int a, input int c, input int h);
    int v, ones;
    e_acc = a; e_cy = c; e_hc = h; e_z = 0; e_s = 0; e_p = 0; e_m = 1;
    case (op)
      0: begin e_acc = ((a * 2) % 256) + a / 128; e_cy = a / 128; end
      1: begin e_acc = a / 2 + (a % 2) * 128; e_cy = a % 2; end
      2: begin e_acc = ((a * 2) % 256) + c; e_cy = a / 128; end
      3: begin e_acc = a / 2 + c * 128; e_cy = a % 2; end
      4: begin
        v = a;
        if ((a % 16) > 9 || h == 1) begin
          e_hc = ((a % 16) > 9) ? 1 : 0;
          v = (v + 6) % 256;
        end else e_hc = 0;
        if ((v / 16) > 9 || c == 1) begin
          e_cy = ((v / 16) > 9) ? 1 : 0;
          v = (v + 96) % 256;
        end else e_cy = 0;
        e_acc = v;
        e_z = (v == 0) ? 1 : 0;
        e_s = v / 128;
        ones = 0;
        for (int b = 0; b < 8; b++) ones += (v >> b) & 1;
        e_p = (ones % 2 == 0) ? 1 : 0;
        e_m = 31;
      end
      5: begin e_acc = 255 - a; e_m = 0; end
      6: e_cy = 1;
      default: e_cy = 1 - c;
    endcase
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (op=%0d acc=%0d cy=%0b hc=%0b)",
               tag, what, act, exp, op_sel, acc_in, cy_in, hc_in);
    end
  endtask

  initial begin
    op_sel = 3'd5; acc_in = 8'h00; cy_in = 1'b0; hc_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // initial idle vector: R9 invert of zero, R11 no zsp
    check("R9", "acc", int'(acc_out), 255);
    check("R11", "zsp", int'({zero_out, sign_out, par_out}), 0);
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int ch = 0; ch < 4; ch++) begin
          @(posedge clk);
          #1;
          op_sel = 3'(op); acc_in = 8'(a); cy_in = ch[0]; hc_in = ch[1];
          @(negedge clk);
          model(op, a, ch & 1, ch / 2);
          check(tag_of(op), "acc", int'(acc_out), e_acc);
          check(tag_of(op), "carry", int'(cy_out), e_cy);
          check((op < 4) ? "R5" : (op == 4 ? "R6" : tag_of(op)), "half", int'(hc_out), e_hc);
          check((op == 4) ? "R8" : "R11", "zero", int'(zero_out), e_z);
          check((op == 4) ? "R8" : "R11", "sign", int'(sign_out), e_s);
          check((op == 4) ? "R8" : "R11", "parity", int'(par_out), e_p);
          check("R12", "mask", int'(upd_mask), e_m);
        end
    // corner: R7 carry in set but high nibble small clears carry
    @(posedge clk); #1;
    op_sel = 3'd4; acc_in = 8'h12; cy_in = 1'b1; hc_in = 1'b0;
    @(negedge clk);
    check("R7", "acc", int'(acc_out), 'h72);
    check("R7", "carry", int'(cy_out), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule